// File: doc/BRIEF.md
# Quadrature Up/Down Counter with Sticky Status

This block counts position steps from an incremental encoder. Each of the A, B and index inputs goes through a two-stage synchroniser. The block then decodes one count per full quadrature cycle (x1). In pulse mode it counts each rising edge of A instead, and B gives the direction. The active count width is chosen at run time as 8, 16, 24 or 32 bits. The counter wraps at the chosen width. An optional range-limit mode holds the count between zero and the preset value.

Next to the count, the block keeps a status byte. The byte holds sticky event flags for carry, borrow, compare and index, a power-loss flag, and three live bits: count enable, direction and sign. The host can clear the counter, load it from the preset input, and clear the status flags. A flag whose condition still holds while the inputs are idle cannot be cleared.

Top module: `quad_updown_counter`

## Requirements
- R1: After reset the count is zero and the status byte has only the power-loss flag (bit 2) set, with bit 3 showing the live `count_en` input.
- R2: With `quad_mode`=1, the count rises by one when A rises while B is low (A leads B). It falls by one when A falls while B is low (B leads A). All other legal transitions leave the count unchanged. The count changes three clock edges after the input change.
- R3: With `quad_mode`=0, every rising edge of A counts up when B=1 and counts down when B=0. Falling edges of A do not count.
- R4: `width_sel` encodes the active width as 0=8, 1=16, 2=24, 3=32 bits. The count wraps at all ones of that width.
- R5: Wrapping up from all ones to zero sets carry (bit 7) and clears sign (bit 0). Wrapping down from zero to all ones sets borrow (bit 6) and sets sign.
- R6: A step that lands on the preset value sets compare (bit 5). A rising edge of the index input sets the index flag (bit 4).
- R7: Status bit 1 gives the direction of the most recent step (1 = up).
- R8: A `clr_stat` strobe clears carry, borrow, compare, index, power-loss and sign. It leaves count enable and direction unchanged.
- R9: When no step occurs in the strobe cycle, and in pulse mode A is also low, `clr_stat` keeps some flags set. Carry stays if the count is all ones and the direction is up. Borrow stays if the count is zero and the direction is down. Compare stays if the count equals the preset.
- R10: With `range_limit`=1, up steps at count == preset and down steps at count == 0 leave the count unchanged.
- R11: With `range_limit`=1, `clr_cnt` is ignored while the count equals the preset with direction up. `load_cnt` is ignored while the count is zero with direction down.
- R12: While `count_en`=0 no step changes the count.
- R13: `clr_cnt` sets the count to zero and takes priority over `load_cnt`. `load_cnt` copies the preset (masked to the width) into the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Enables counting |
| quad_mode | input | 1 | 1 = quadrature x1, 0 = pulse/direction |
| range_limit | input | 1 | Holds the count between zero and the preset |
| width_sel | input | 2 | Active width: 0=8, 1=16, 2=24, 3=32 bits |
| in_a | input | 1 | Encoder A (asynchronous) |
| in_b | input | 1 | Encoder B or direction (asynchronous) |
| in_idx | input | 1 | Index marker (asynchronous) |
| preset | input | 32 | Compare and load value |
| clr_cnt | input | 1 | Strobe: clear the count |
| load_cnt | input | 1 | Strobe: load the count from the preset |
| clr_stat | input | 1 | Strobe: clear the status flags |
| count | output | 32 | Count, masked to the active width |
| status | output | 8 | Carry, borrow, compare, index, enable, power-loss, direction, sign (bit 7 down to 0) |

## Verification
The bench builds the block with its default 32-bit maximum width and a two-stage synchroniser. Every run-time width can therefore be selected. The bench runs the 8-bit width through a full quadrature sweep that ends in a borrow wrap. It uses the 16-bit width to show that the wrap point moves with `width_sel`. With the 8-bit width, the all-ones and zero bounds are a few steps away. This lets the bench exercise the flags that resist clearing and the range-limit gating of clear and load without long count runs.

// File: rtl/qc_pkg.sv
package qc_pkg;
   localparam int ST_CY  = 7;
   localparam int ST_BW  = 6;
   localparam int ST_CMP = 5;
   localparam int ST_IDX = 4;
   localparam int ST_CEN = 3;
   localparam int ST_PLS = 2;
   localparam int ST_DIR = 1;
   localparam int ST_SGN = 0;

   typedef enum logic [1:0] {
      QC_W8  = 2'd0,
      QC_W16 = 2'd1,
      QC_W24 = 2'd2,
      QC_W32 = 2'd3
   } qc_width_e;
endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("qc_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qc_stepdec.sv
module qc_stepdec (
   input  logic clk,
   input  logic rst_n,
   input  logic quad_mode,
   input  logic a_s,
   input  logic b_s,
   output logic step_up,
   output logic step_dn
);
   logic a_prev, b_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
      end else begin
         a_prev <= a_s;
         b_prev <= b_s;
      end
   end

   always_comb begin
      step_up = 1'b0;
      step_dn = 1'b0;
      if (quad_mode) begin
         case ({a_prev, b_prev, a_s, b_s})
            4'b0010: step_up = 1'b1;
            4'b1000: step_dn = 1'b1;
            default: ;
         endcase
      end else if (!a_prev && a_s) begin
         step_up = b_s;
         step_dn = !b_s;
      end
   end

   // R2: the decoder never reports both directions at once
   a_r2_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up && step_dn));
endmodule

// File: rtl/qc_status.sv
module qc_status
   import qc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       count_en,
   input  logic       step_up,
   input  logic       step_dn,
   input  logic       wrap_up,
   input  logic       wrap_dn,
   input  logic       cmp_hit,
   input  logic       idx_rise,
   input  logic       clr_stat,
   input  logic       hold_cy,
   input  logic       hold_bw,
   input  logic       hold_cmp,
   output logic [7:0] status
);
   logic cy_q, bw_q, cmp_q, idx_q, pls_q, dir_q, sgn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cy_q  <= 1'b0;
         bw_q  <= 1'b0;
         cmp_q <= 1'b0;
         idx_q <= 1'b0;
         pls_q <= 1'b1;
         dir_q <= 1'b0;
         sgn_q <= 1'b0;
      end else begin
         cy_q  <= (cy_q  & ~(clr_stat & ~hold_cy))  | wrap_up;
         bw_q  <= (bw_q  & ~(clr_stat & ~hold_bw))  | wrap_dn;
         cmp_q <= (cmp_q & ~(clr_stat & ~hold_cmp)) | cmp_hit;
         idx_q <= (idx_q & ~clr_stat) | idx_rise;
         pls_q <= pls_q & ~clr_stat;
         if (step_up)      dir_q <= 1'b1;
         else if (step_dn) dir_q <= 1'b0;
         if (wrap_dn)       sgn_q <= 1'b1;
         else if (wrap_up)  sgn_q <= 1'b0;
         else if (clr_stat) sgn_q <= 1'b0;
      end
   end

   always_comb begin
      status         = '0;
      status[ST_CY]  = cy_q;
      status[ST_BW]  = bw_q;
      status[ST_CMP] = cmp_q;
      status[ST_IDX] = idx_q;
      status[ST_CEN] = count_en;
      status[ST_PLS] = pls_q;
      status[ST_DIR] = dir_q;
      status[ST_SGN] = sgn_q;
   end

   // R8: a clear-status strobe always drops the power-loss flag
   a_r8_pls_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stat |=> !status[ST_PLS]);
   // R5: a down wrap leaves sign set
   a_r5_sign_on_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_dn |=> (status[ST_SGN] && status[ST_BW]));
   // R8: direction is untouched by clear-status when no step occurs
   a_r8_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stat && !step_up && !step_dn) |=> $stable(status[ST_DIR]));
endmodule

// File: rtl/quad_updown_counter.sv
module quad_updown_counter
   import qc_pkg::*;
#(
   parameter int MAX_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             quad_mode,
   input  logic             range_limit,
   input  logic [1:0]       width_sel,
   input  logic             in_a,
   input  logic             in_b,
   input  logic             in_idx,
   input  logic [MAX_W-1:0] preset,
   input  logic             clr_cnt,
   input  logic             load_cnt,
   input  logic             clr_stat,
   output logic [MAX_W-1:0] count,
   output logic [7:0]       status
);
   localparam int BYTE_W = 8;

   generate
      if (MAX_W < BYTE_W || MAX_W > 32 || (MAX_W % BYTE_W) != 0) begin : g_bad_w
         $error("MAX_W must be 8, 16, 24 or 32");
      end
   endgenerate

   logic [2:0] raw_in, syn_in;
   logic       a_s, b_s, idx_s, idx_prev;
   logic       up_raw, dn_raw, up_g, dn_g;

   assign raw_in = {in_idx, in_b, in_a};

   qc_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

   assign a_s   = syn_in[0];
   assign b_s   = syn_in[1];
   assign idx_s = syn_in[2];

   qc_stepdec u_dec (
      .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode),
      .a_s(a_s), .b_s(b_s), .step_up(up_raw), .step_dn(dn_raw));

   assign up_g = up_raw & count_en;
   assign dn_g = dn_raw & count_en;

   // active-width mask
   logic [MAX_W-1:0] mask;
   logic [MAX_W:0]   lim;
   int unsigned      nbits;

   always_comb begin
      nbits = (int'(width_sel) + 1) * BYTE_W;
      if (nbits > MAX_W) nbits = MAX_W;
      lim  = {{MAX_W{1'b0}}, 1'b1} << nbits;
      mask = MAX_W'(lim - 1'b1);
   end

   logic [MAX_W-1:0] cnt_q, cnt_d, cm, pre_m;
   logic             at_top, at_zero, at_pre, dir_up;
   logic             clr_ok, load_ok, wrap_up, wrap_dn, cmp_hit, halted;

   assign cm      = cnt_q & mask;
   assign pre_m   = preset & mask;
   assign at_top  = (cm == mask);
   assign at_zero = (cm == '0);
   assign at_pre  = (cm == pre_m);
   assign dir_up  = status[ST_DIR];
   assign clr_ok  = !(range_limit && at_pre && dir_up);
   assign load_ok = !(range_limit && at_zero && !dir_up);

   always_comb begin
      cnt_d   = cm;
      wrap_up = 1'b0;
      wrap_dn = 1'b0;
      cmp_hit = 1'b0;
      if (clr_cnt && clr_ok) begin
         cnt_d = '0;
      end else if (load_cnt && load_ok) begin
         cnt_d = pre_m;
      end else if (up_g && !(range_limit && at_pre)) begin
         if (at_top) begin
            cnt_d   = '0;
            wrap_up = 1'b1;
         end else begin
            cnt_d = (cm + 1'b1) & mask;
         end
         cmp_hit = (cnt_d == pre_m);
      end else if (dn_g && !(range_limit && at_zero)) begin
         if (at_zero) begin
            cnt_d   = mask;
            wrap_dn = 1'b1;
         end else begin
            cnt_d = cm - 1'b1;
         end
         cmp_hit = (cnt_d == pre_m);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         idx_prev <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         idx_prev <= idx_s;
      end
   end

   assign halted = !up_raw && !dn_raw && (quad_mode || !a_s);

   qc_status u_stat (
      .clk(clk), .rst_n(rst_n), .count_en(count_en),
      .step_up(up_g), .step_dn(dn_g),
      .wrap_up(wrap_up), .wrap_dn(wrap_dn), .cmp_hit(cmp_hit),
      .idx_rise(idx_s && !idx_prev), .clr_stat(clr_stat),
      .hold_cy(halted && at_top && dir_up),
      .hold_bw(halted && at_zero && !dir_up),
      .hold_cmp(halted && at_pre),
      .status(status));

   assign count = cm;

   // R5: an up step at all ones wraps to zero and sets carry
   a_r5_carry_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (up_g && at_top && !range_limit && !clr_cnt && !load_cnt)
      |=> (cnt_q == '0 && status[ST_CY]));
   // R10: an up step at the preset bound is frozen
   a_r10_freeze_up: assert property (@(posedge clk) disable iff (!rst_n)
      (range_limit && up_g && at_pre && !clr_cnt && !load_cnt)
      |=> (cnt_q == $past(cm)));
   // R11: clear is refused while frozen at the preset going up
   a_r11_clr_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (range_limit && clr_cnt && at_pre && dir_up && !load_cnt && !dn_g)
      |=> (cnt_q == $past(cm)));
   // R12: no count change while disabled without strobes
   a_r12_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !clr_cnt && !load_cnt) |=> (cnt_q == $past(cm)));
endmodule

// File: tb/test_quad_updown_counter.sv
module test_quad_updown_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        count_en = 1'b0, quad_mode = 1'b1, range_limit = 1'b0;
   logic [1:0]  width_sel = 2'd0;
   logic        in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
   logic [31:0] preset = 32'h80;
   logic        clr_cnt = 1'b0, load_cnt = 1'b0, clr_stat = 1'b0;
   logic [31:0] count;
   logic [7:0]  status;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   quad_updown_counter i_quad_updown_counter (
      .clk(clk), .rst_n(rst_n), .count_en(count_en), .quad_mode(quad_mode),
      .range_limit(range_limit), .width_sel(width_sel), .in_a(in_a),
      .in_b(in_b), .in_idx(in_idx), .preset(preset), .clr_cnt(clr_cnt),
      .load_cnt(load_cnt), .clr_stat(clr_stat), .count(count), .status(status));

   // {a, b, expected 8-bit count}, starting from count 0, AB = 00, width 8
   localparam logic [9:0] VEC [0:13] = '{
      {1'b1, 1'b0, 8'h01}, {1'b1, 1'b1, 8'h01}, {1'b0, 1'b1, 8'h01},
      {1'b0, 1'b0, 8'h01}, {1'b1, 1'b0, 8'h02}, {1'b0, 1'b0, 8'h01},
      {1'b0, 1'b1, 8'h01}, {1'b1, 1'b1, 8'h01}, {1'b1, 1'b0, 8'h01},
      {1'b0, 1'b0, 8'h00}, {1'b0, 1'b1, 8'h00}, {1'b1, 1'b1, 8'h00},
      {1'b1, 1'b0, 8'h00}, {1'b0, 1'b0, 8'hFF}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   // which: 0 = clr_cnt, 1 = load_cnt, 2 = clr_stat
   task automatic strobe(input int which);
      @(negedge clk);
      if (which == 0) clr_cnt = 1'b1;
      else if (which == 1) load_cnt = 1'b1;
      else clr_stat = 1'b1;
      @(negedge clk);
      clr_cnt = 1'b0; load_cnt = 1'b0; clr_stat = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_a();
      in_a = 1'b1; settle();
      in_a = 1'b0; settle();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count after reset", count, 32'h0);
      chk("R1 status after reset", {24'h0, status}, 32'h04);
      count_en = 1'b1;
      @(negedge clk);
      chk("R1 live enable bit", {24'h0, status}, 32'h0C);

      // R2 quadrature sweep: forward, bounce, reverse, borrow wrap
      for (int i = 0; i < 14; i++) begin
         in_a = VEC[i][9]; in_b = VEC[i][8];
         settle();
         chk("R2 quadrature step", count, {24'h0, VEC[i][7:0]});
      end
      chk("R5 R7 status after borrow", {24'h0, status}, 32'h4D);

      strobe(2);
      chk("R8 clear-status", {24'h0, status}, 32'h08);

      in_a = 1'b1; settle();
      chk("R4 8-bit up wrap", count, 32'h0);
      chk("R5 carry sets, sign clears", {24'h0, status}, 32'h8A);

      preset = 32'hFF;
      strobe(1);
      chk("R13 load from preset", count, 32'hFF);
      strobe(2);
      chk("R9 carry held at all ones going up", {24'h0, status}, 32'h8A);

      // pulse mode
      quad_mode = 1'b0;
      in_a = 1'b0; settle();
      strobe(0);
      chk("R13 clear count", count, 32'h0);
      in_b = 1'b1;
      pulse_a();
      chk("R3 pulse counts up with B high", count, 32'h1);
      chk("R7 direction up", {31'h0, status[1]}, 32'h1);
      strobe(2);
      chk("R8 carry cleared away from bound", {31'h0, status[7]}, 32'h0);

      width_sel = 2'd1;
      preset = 32'hFFFF;
      strobe(1);
      chk("R4 16-bit load", count, 32'hFFFF);
      pulse_a();
      chk("R4 16-bit wrap", count, 32'h0);
      chk("R5 carry at 16 bits", {31'h0, status[7]}, 32'h1);

      // range limit
      range_limit = 1'b1;
      preset = 32'h3;
      strobe(0);
      for (int k = 0; k < 5; k++) pulse_a();
      chk("R10 frozen at preset", count, 32'h3);
      chk("R6 compare latched", {31'h0, status[5]}, 32'h1);
      strobe(0);
      chk("R11 clear refused at upper bound", count, 32'h3);
      in_b = 1'b0;
      pulse_a();
      chk("R3 pulse counts down with B low", count, 32'h2);
      strobe(0);
      chk("R11 clear after reversal", count, 32'h0);
      strobe(1);
      chk("R11 load refused at zero going down", count, 32'h0);
      pulse_a();
      chk("R10 frozen at zero", count, 32'h0);
      in_b = 1'b1;
      pulse_a();
      strobe(1);
      chk("R11 load after reversal", count, 32'h3);

      strobe(2);
      chk("R9 compare held with A low", {31'h0, status[5]}, 32'h1);
      chk("R8 carry cleared", {31'h0, status[7]}, 32'h0);

      in_idx = 1'b1; settle();
      in_idx = 1'b0; settle();
      chk("R6 index latched", {31'h0, status[4]}, 32'h1);

      count_en = 1'b0;
      in_b = 1'b0;
      pulse_a();
      chk("R12 no count while disabled", count, 32'h3);
      chk("R12 enable bit low", {31'h0, status[3]}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule